// File: doc/BRIEF.md
# Port Pin Edge Interrupt Controller

This block watches one port of pins that have already been synchronised to the clock. Each pin has its own 2-bit edge-type field. When a pin shows an edge that its field accepts, a sticky status bit is posted for that pin. All posted bits together drive one level-type interrupt request for the port. That request is also ORed with an incoming wakeup line, so several ports can be chained onto one wakeup wire.

Firmware uses a small register port. Each pin's type field has its own address. Reading the status address returns the posted bits and clears them, unless a port-wide keep bit is set. The same read also captures the current pin levels into a snapshot register, which can be read afterwards to see the pin state at the moment of service. Read data is combinational from the address. Read side effects and writes take effect at the clock edge that ends the access cycle.

Top module: `pei_port_irq`

## Requirements
- R1: Type field encoding, at address k (0..NPINS-1), bits [1:0] for pin k: 00 = pin off, 01 = rising edge only, 10 = falling edge only, 11 = either edge. The field reads back what was written.
- R2: A pin level seen at a clock edge that differs from the level seen one clock earlier, and that the pin's type field accepts, sets status bit k at that clock edge. The bit stays set until a clearing read or reset.
- R3: The status register is at address NPINS. A read returns the posted bits. If control bit 0 (keep, at address NPINS+2) is 0, the read clears the bits at that clock edge. If keep is 1, the status is unchanged.
- R4: Every status read loads the pin levels sampled at that clock edge into the snapshot register at address NPINS+1.
- R5: An accepted edge in the same cycle as a clearing read leaves its status bit set.
- R6: irq_o is high exactly while at least one status bit is set.
- R7: wake_o equals irq_o OR wake_i.
- R8: A type write takes effect from the following cycle. An edge sampled in the write cycle is judged by the old field. Writing a type while pins are steady posts nothing. Edges on pins set to 00 post nothing.
- R9: After reset, the type fields, status, snapshot, keep bit and irq_o are all 0. Addresses beyond NPINS+2 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pins_i | input | NPINS | Synchronised pin levels |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (side effects on status read) |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i |
| wake_i | input | 1 | Wakeup from the previous port in the chain |
| irq_o | output | 1 | Port interrupt request (level) |
| wake_o | output | 1 | Wakeup to the next port in the chain |

## Verification
The bench sweeps every type code on every pin with both edge directions. A wrong decode would post a falling edge under a rising-only code, or miss one of the two directions under the any-edge code. It places an edge in the same cycle as a clearing read; a design that lets the clear win would drop that event and leave irq_o low. It changes a type field in the same cycle as an edge, where early use of the new field would post a spurious bit. It also checks that the keep bit preserves status across repeated reads, and that the snapshot holds the pin pattern from the read cycle rather than a later one.

// File: rtl/pei_pkg.sv
package pei_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;

  localparam int DATA_W = 8;
endpackage

// File: rtl/pei_edge_detect.sv
module pei_edge_detect #(
  parameter int NPINS = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NPINS-1:0]   pins_i,
  input  logic [2*NPINS-1:0] types_i,
  output logic [NPINS-1:0]   hit_o
);
  import pei_pkg::*;

  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] prev_d;

  always_comb prev_d = pins_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= prev_d;
  end

  for (genvar k = 0; k < NPINS; k++) begin : g_pin
    edge_sel_e sel;
    logic      rise;
    logic      fall;
    always_comb begin
      sel  = edge_sel_e'(types_i[2*k +: 2]);
      rise = pins_i[k] & ~prev_q[k];
      fall = ~pins_i[k] & prev_q[k];
      unique case (sel)
        EDGE_RISE: hit_o[k] = rise;
        EDGE_FALL: hit_o[k] = fall;
        EDGE_ANY:  hit_o[k] = rise | fall;
        default:   hit_o[k] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/pei_regs.sv
module pei_regs #(
  parameter int NPINS  = 8,
  parameter int ADDR_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [7:0]         wdata_i,
  output logic [2*NPINS-1:0] types_o,
  output logic               keep_o
);
  localparam int CTRL_ADDR = NPINS + 2;

  for (genvar k = 0; k < NPINS; k++) begin : g_type
    logic       en;
    logic [1:0] typ_q;
    logic [1:0] typ_d;
    always_comb begin
      en    = wr_i && (int'(addr_i) == k);
      typ_d = en ? wdata_i[1:0] : typ_q;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) typ_q <= 2'b00;
      else         typ_q <= typ_d;
    end
    assign types_o[2*k +: 2] = typ_q;
  end

  logic keep_q;
  logic keep_d;
  logic keep_en;

  always_comb begin
    keep_en = wr_i && (int'(addr_i) == CTRL_ADDR);
    keep_d  = keep_en ? wdata_i[0] : keep_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) keep_q <= 1'b0;
    else         keep_q <= keep_d;
  end

  assign keep_o = keep_q;
endmodule

// File: rtl/pei_status.sv
module pei_status #(
  parameter int NPINS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pins_i,
  input  logic [NPINS-1:0] hit_i,
  input  logic             rd_i,
  input  logic             keep_i,
  output logic [NPINS-1:0] status_o,
  output logic [NPINS-1:0] snap_o
);
  logic [NPINS-1:0] status_q, status_d;
  logic [NPINS-1:0] snap_q, snap_d;
  logic             clr;

  always_comb begin
    clr      = rd_i && !keep_i;
    status_d = (clr ? '0 : status_q) | hit_i;
    snap_d   = rd_i ? pins_i : snap_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      snap_q   <= '0;
    end else begin
      status_q <= status_d;
      snap_q   <= snap_d;
    end
  end

  assign status_o = status_q;
  assign snap_o   = snap_q;
endmodule

// File: rtl/pei_port_irq.sv
module pei_port_irq #(
  parameter int NPINS  = 8,
  parameter int ADDR_W = $clog2(NPINS + 3)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPINS-1:0]  pins_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  input  logic              wake_i,
  output logic              irq_o,
  output logic              wake_o
);
  localparam int STAT_ADDR = NPINS;
  localparam int SNAP_ADDR = NPINS + 1;
  localparam int CTRL_ADDR = NPINS + 2;

  logic [2*NPINS-1:0] types;
  logic               keep_q;
  logic [NPINS-1:0]   hit;
  logic [NPINS-1:0]   status_q;
  logic [NPINS-1:0]   snap_q;
  logic               rd_stat;

  assign rd_stat = bus_rd_i && (int'(bus_addr_i) == STAT_ADDR);

  pei_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) regs_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (bus_wr_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .types_o (types),
    .keep_o  (keep_q)
  );

  pei_edge_detect #(.NPINS(NPINS)) edge_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pins_i  (pins_i),
    .types_i (types),
    .hit_o   (hit)
  );

  pei_status #(.NPINS(NPINS)) stat_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pins_i   (pins_i),
    .hit_i    (hit),
    .rd_i     (rd_stat),
    .keep_i   (keep_q),
    .status_o (status_q),
    .snap_o   (snap_q)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (int'(bus_addr_i) < NPINS) begin
      for (int k = 0; k < NPINS; k++)
        if (int'(bus_addr_i) == k) bus_rdata_o[1:0] = types[2*k +: 2];
    end else if (int'(bus_addr_i) == STAT_ADDR) begin
      bus_rdata_o[NPINS-1:0] = status_q;
    end else if (int'(bus_addr_i) == SNAP_ADDR) begin
      bus_rdata_o[NPINS-1:0] = snap_q;
    end else if (int'(bus_addr_i) == CTRL_ADDR) begin
      bus_rdata_o[0] = keep_q;
    end
  end

  assign irq_o  = |status_q;
  assign wake_o = irq_o | wake_i;
endmodule

// File: rtl/pei_port_irq_chk.sv
module pei_port_irq_chk #(
  parameter int NPINS = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NPINS-1:0] pins_i,
  input logic             rd_stat,
  input logic             keep,
  input logic [NPINS-1:0] status,
  input logic [NPINS-1:0] snap,
  input logic             irq_o,
  input logic             wake_i,
  input logic             wake_o
);
  assert_status_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_stat && !keep) |=> (($past(status) & ~status) == '0));

  assert_irq_falls_on_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(rd_stat && !keep));

  assert_snap_capture_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stat |=> (snap == $past(pins_i)));

  assert_wake_chain_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_i || irq_o) |-> wake_o);
endmodule

bind pei_port_irq pei_port_irq_chk #(.NPINS(NPINS)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .pins_i  (pins_i),
  .rd_stat (rd_stat),
  .keep    (keep_q),
  .status  (status_q),
  .snap    (snap_q),
  .irq_o   (irq_o),
  .wake_i  (wake_i),
  .wake_o  (wake_o)
);

// File: tb/pei_port_irq_tb_top.sv
module pei_port_irq_tb_top;
  localparam int N    = 8;
  localparam int AW   = $clog2(N + 3);
  localparam int ST   = N;
  localparam int SNAP = N + 1;
  localparam int CTRL = N + 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  pins;
  logic          wr, rd;
  logic [AW-1:0] addr;
  logic [7:0]    wdata;
  logic [7:0]    rdata;
  logic          wake_in;
  logic          irq, wake_out;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pei_port_irq #(.NPINS(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .wake_i(wake_in), .irq_o(irq), .wake_o(wake_out)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(int a, logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a[AW-1:0]; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(int a, output logic [7:0] d);
    @(negedge clk); rd = 1'b1; addr = a[AW-1:0];
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic peek(int a, output logic [7:0] d);
    @(negedge clk); addr = a[AW-1:0];
    #1 d = rdata;
  endtask

  task automatic set_pins(logic [N-1:0] v);
    @(negedge clk); pins = v;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] exp;
    rst_n = 1'b0; pins = '1; wr = 0; rd = 0; addr = '0; wdata = '0; wake_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R9: reset state
    check("R9 irq", {7'b0, irq}, 8'h00);
    peek(ST, d);   check("R9 status", d, 8'h00);
    peek(SNAP, d); check("R9 snap", d, 8'h00);
    peek(CTRL, d); check("R9 keep", d, 8'h00);
    peek(3, d);    check("R9 type", d, 8'h00);
    peek(N + 3, d); check("R9 unused addr", d, 8'h00);
    set_pins('0);

    // R1 R2 R3 R6: sweep every code on every pin, both directions
    for (int p = 0; p < N; p++) begin
      for (int t = 0; t < 4; t++) begin
        bus_write(p, 8'(t));
        peek(p, d); check("R1 type readback", d, 8'(t));
        set_pins(N'(1) << p);
        exp = (t[0]) ? (8'(1) << p) : 8'h00;
        check("R6 irq after rise", {7'b0, irq}, {7'b0, exp != 0});
        bus_read(ST, d); check("R1 R2 rise status", d, exp);
        bus_read(ST, d); check("R3 cleared", d, 8'h00);
        set_pins('0);
        exp = (t[1]) ? (8'(1) << p) : 8'h00;
        bus_read(ST, d); check("R1 R2 fall status", d, exp);
        check("R6 irq after clear", {7'b0, irq}, 8'h00);
        bus_write(p, 8'h00);
      end
    end

    // R2: sticky over idle cycles
    bus_write(0, 8'h3);
    set_pins(8'h01);
    repeat (5) @(negedge clk);
    check("R2 sticky irq", {7'b0, irq}, 8'h01);
    bus_read(ST, d); check("R2 sticky status", d, 8'h01);
    set_pins(8'h00);
    bus_read(ST, d);

    // R5: edge in the same cycle as a clearing read
    bus_write(0, 8'h1);
    bus_write(1, 8'h3);
    set_pins(8'h02);
    @(negedge clk); pins = 8'h03; rd = 1'b1; addr = ST[AW-1:0];
    #1 check("R5 read data before edge", rdata, 8'h02);
    @(negedge clk); rd = 1'b0;
    check("R5 irq kept", {7'b0, irq}, 8'h01);
    bus_read(ST, d); check("R5 status kept", d, 8'h01);

    // R3: keep bit
    bus_write(CTRL, 8'h01);
    set_pins(8'h00);
    bus_read(ST, d); check("R3 keep read 1", d, 8'h02);
    bus_read(ST, d); check("R3 keep read 2", d, 8'h02);
    check("R3 keep irq", {7'b0, irq}, 8'h01);
    bus_write(CTRL, 8'h00);
    bus_read(ST, d); check("R3 clear after keep", d, 8'h02);
    bus_read(ST, d); check("R3 now empty", d, 8'h00);
    bus_write(0, 8'h0);
    bus_write(1, 8'h0);

    // R4: snapshot
    set_pins(8'hA5);
    bus_read(ST, d);
    pins = 8'h3C;
    bus_read(SNAP, d); check("R4 snapshot A5", d, 8'hA5);
    bus_read(ST, d);
    pins = 8'h00;
    bus_read(SNAP, d); check("R4 snapshot 3C", d, 8'h3C);

    // R8: write type in the same cycle as an edge; write while steady
    @(negedge clk); pins = 8'h10; wr = 1'b1; addr = 4; wdata = 8'h1;
    @(negedge clk); wr = 1'b0;
    @(negedge clk);
    bus_read(ST, d); check("R8 old type judged", d, 8'h00);
    bus_write(4, 8'h3);
    bus_write(2, 8'h3);
    repeat (2) @(negedge clk);
    bus_read(ST, d); check("R8 steady write", d, 8'h00);
    bus_write(4, 8'h0);
    set_pins(8'h00);
    bus_read(ST, d); check("R8 disabled pin", d, 8'h00);
    bus_write(2, 8'h0);

    // R7: wake chain
    @(negedge clk); wake_in = 1'b1;
    #1 check("R7 wake in only", {7'b0, wake_out}, 8'h01);
    @(negedge clk); wake_in = 1'b0;
    #1 check("R7 idle", {7'b0, wake_out}, 8'h00);
    bus_write(5, 8'h2);
    set_pins(8'h20);
    set_pins(8'h00);
    check("R7 wake from irq", {7'b0, wake_out}, 8'h01);
    bus_read(ST, d); check("R7 status", d, 8'h20);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule